// File: doc/BRIEF.md
# Serial DAC Input Register

This block is the device-side receiver of a three-wire serial link (bit clock, data, latch enable) feeding a 16-bit digital-to-analog converter. Data is captured on every falling edge of the bit clock and moved in at the least significant end of a free-running shift register, so the word arrives most significant bit first. There is no word counter. On a falling edge of latch enable, whatever sixteen bits arrived last are copied into the parallel DAC input register.

All three pins are asynchronous to the block. They are sampled by a fast system clock through two-flop synchronizers, and their edges are found in that domain. The system clock must therefore run at least about four times the bit-clock rate, with each bit-clock phase lasting at least two system clocks. The latched word is a two's-complement code. A second output gives the same code in offset-binary form for a current-steering array. A one-cycle strobe marks each update.

Top module: `sdac_rx`

## Requirements
- R1: On each falling edge of `sclk_i`, the value on `sdata_i` enters bit 0 of the shift register and every older bit moves one place towards bit 15. So a word sent most significant bit first ends up in its natural order.
- R2: A falling edge of `latch_i` loads `code_o` with the sixteen bits most recently shifted in.
- R3: When more than sixteen bits arrive between two latch falling edges, only the last sixteen appear in `code_o`.
- R4: When k bits fewer than sixteen arrive, `code_o` equals the previous shift register contents shifted up by k places, with the k new bits in bits k-1..0.
- R5: `upd_o` is high for exactly one system clock, in the cycle that `code_o` takes its new value, once per latch falling edge. At all other times it is low.
- R6: A rising edge of `latch_i` does not change `code_o` or raise `upd_o`, and `code_o` holds its value between latch falling edges.
- R7: `code_ob_o` equals `code_o` with bit 15 inverted (two's complement to offset binary).
- R8: After synchronous active-low reset, `code_o` is 0x0000, `code_ob_o` is 0x8000, `upd_o` is low, and the shift register holds zero. A latch with no bits sent then yields 0x0000.
- R9: `upd_o` rises no later than four system clocks after the falling edge of `latch_i` at the pin.
- R10: Changes of `sdata_i` while `sclk_i` is high, and rising edges of `sclk_i`, shift nothing in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial bit clock, asynchronous |
| sdata_i | input | 1 | Serial data, MSB first |
| latch_i | input | 1 | Latch enable; its falling edge loads the word |
| code_o | output | 16 | Latched two's-complement code |
| code_ob_o | output | 16 | Latched code in offset binary |
| upd_o | output | 1 | One-cycle strobe on each load |

## Verification
The bench sends words of random length, from a few bits to well past sixteen, and compares each latched word with a software shift model. Short words catch a design that clears the register or counts bits; it would zero the stale upper bits. Long words catch a design that stops after sixteen bits; it would keep the first bits instead of the last. The bench toggles data while the bit clock is high and raises latch alone, which exposes a design that samples on the wrong edge or loads on the wrong latch edge. Counting strobes per latch edge catches a level-sensitive load, which would produce a multi-cycle or repeated pulse.

// File: rtl/sdac_pkg.sv
// Package: shared types for the serial DAC input register.
// Assumes: nothing beyond standard SystemVerilog.
package sdac_pkg;

    // Bundle of the three serial pins, in a fixed order for the synchronizer
    typedef struct packed {
        logic sclk;
        logic sdata;
        logic latch;
    } sdac_pins_t;

    localparam int unsigned SDAC_PIN_W = $bits(sdac_pins_t);

endpackage

// File: rtl/sdac_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes: each bit is an independent level; reset drives all stages to 0,
// so a pin idling high produces only a rising edge after reset.
module sdac_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    // Shift the asynchronous levels through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/sdac_fall.sv
// Module: falling-edge detector for synchronized levels.
// Assumes: inputs are already in the clk domain; output is combinational
// and high for one cycle per 1->0 transition.
module sdac_fall #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] fall
);

    logic [W-1:0] lvl_d;

    // Remember the previous level of each input
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d <= '0;
        else        lvl_d <= lvl;
    end

    assign fall = lvl_d & ~lvl;

endmodule

// File: rtl/sdac_shift.sv
// Module: free-running shift register, new bit enters at bit 0.
// Assumes: no word count; older bits fall off the top.
module sdac_shift #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q
);

    // Move the register up one place and insert the new bit on each enable
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= {q[W-2:0], din};
    end

endmodule

// File: rtl/sdac_rx.sv
// Module: serial DAC input register (top).
// Synchronizes bit clock, data and latch enable, shifts data on bit-clock
// falling edges and loads the parallel code on latch-enable falling edges.
// Assumes: clk runs at least 4x the bit clock, and each pin phase lasts at
// least two clk cycles. Latch and bit-clock falling edges do not coincide;
// if they do, the latch takes the word before the new bit.
module sdac_rx #(
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned SYNC_STAGES = 2,
    parameter bit          OB_EN       = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              sdata_i,
    input  logic              latch_i,
    output logic [DATA_W-1:0] code_o,
    output logic [DATA_W-1:0] code_ob_o,
    output logic              upd_o
);
    import sdac_pkg::*;

    localparam int unsigned MSB = DATA_W - 1;

    sdac_pins_t         pins_raw;
    sdac_pins_t         pins_s;
    logic               sclk_fall;
    logic               latch_fall;
    logic               data_s;
    logic [DATA_W-1:0]  sh_word;
    logic [DATA_W-1:0]  word_q;
    logic               upd_q;
    logic [1:0]         falls;

    assign pins_raw = '{sclk: sclk_i, sdata: sdata_i, latch: latch_i};

    sdac_sync #(.W(SDAC_PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_raw),
        .q     (pins_s)
    );

    sdac_fall #(.W(2)) u_fall (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   ({pins_s.sclk, pins_s.latch}),
        .fall  (falls)
    );

    assign sclk_fall  = falls[1];
    assign latch_fall = falls[0];
    assign data_s     = pins_s.sdata;

    sdac_shift #(.W(DATA_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (sclk_fall),
        .din   (data_s),
        .q     (sh_word)
    );

    // Load the parallel register and raise the strobe on a latch falling edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            upd_q  <= 1'b0;
        end else begin
            upd_q <= latch_fall;
            if (latch_fall) word_q <= sh_word;
        end
    end

    assign code_o = word_q;
    assign upd_o  = upd_q;

    generate
        if (OB_EN) begin : g_ob
            assign code_ob_o = {~word_q[MSB], word_q[MSB-1:0]};
        end else begin : g_tc
            assign code_ob_o = word_q;
        end
    endgenerate

endmodule

// File: rtl/sdac_rx_chk.sv
// Module: assertion checker for sdac_rx, attached by bind.
// Assumes: the default offset-binary variant.
module sdac_rx_chk #(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sclk_fall,
    input logic              latch_fall,
    input logic              data_s,
    input logic [DATA_W-1:0] sh_word,
    input logic [DATA_W-1:0] code_o,
    input logic [DATA_W-1:0] code_ob_o,
    input logic              upd_o
);

    p_shift_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_fall |=> sh_word == {$past(sh_word[DATA_W-2:0]), $past(data_s)});

    p_load_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> code_o == $past(sh_word));

    p_strobe_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        latch_fall |=> upd_o);

    p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |=> !upd_o);

    p_code_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_o |-> code_o == $past(code_o));

    p_ob_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (code_ob_o[DATA_W-1] != code_o[DATA_W-1]) &&
        (code_ob_o[DATA_W-2:0] == code_o[DATA_W-2:0]));

    p_reset_state_r8: assert property (@(posedge clk)
        !rst_n |=> (code_o == '0) && !upd_o);

endmodule

bind sdac_rx sdac_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_fall  (sclk_fall),
    .latch_fall (latch_fall),
    .data_s     (data_s),
    .sh_word    (sh_word),
    .code_o     (code_o),
    .code_ob_o  (code_ob_o),
    .upd_o      (upd_o)
);

// File: tb/sdac_rx_tb.sv
module sdac_rx_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk_i = 1'b1;
    logic        sdata_i = 1'b0;
    logic        latch_i = 1'b1;
    logic [15:0] code_o;
    logic [15:0] code_ob_o;
    logic        upd_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] model_sh = '0;
    logic [15:0] model_code = '0;
    bit done = 1'b0;

    sdac_rx u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_i    (sclk_i),
        .sdata_i   (sdata_i),
        .latch_i   (latch_i),
        .code_o    (code_o),
        .code_ob_o (code_ob_o),
        .upd_o     (upd_o)
    );

    always #2 clk = ~clk;

    function automatic logic [15:0] to_ob(input logic [15:0] c);
        return {~c[15], c[14:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // One bit: set data while the bit clock is high, then a full low phase
    task automatic send_bit(input logic b);
        sdata_i = b;
        wait_clk(2);
        sclk_i = 1'b0;
        wait_clk(4);
        sclk_i = 1'b1;
        wait_clk(2);
        model_sh = {model_sh[14:0], b};
    endtask

    // Latch falling edge; verify latency, strobe count, word and offset code
    task automatic do_latch(input string req);
        int first = -1;
        int pulses = 0;
        latch_i = 1'b1;
        wait_clk(4);
        latch_i = 1'b0;
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            if (upd_o) begin
                pulses++;
                if (first < 0) begin
                    first = i;
                    model_code = model_sh;
                    check({req, " word"}, {16'h0, code_o}, {16'h0, model_code});
                    check({req, " R7 ob"}, {16'h0, code_ob_o}, {16'h0, to_ob(model_code)});
                end
            end
        end
        check("R5 one strobe", pulses, 1);
        check("R9 latency<=4", (first >= 1 && first <= 4) ? 1 : 0, 1);
        latch_i = 1'b1;
        wait_clk(4);
    endtask

    task automatic send_word(input logic [31:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(w[i]);
    endtask

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        wait_clk(5);
        // R8 reset values
        check("R8 code", {16'h0, code_o}, 32'h0);
        check("R8 ob", {16'h0, code_ob_o}, 32'h8000);
        check("R8 upd", {31'h0, upd_o}, 32'h0);
        rst_n = 1'b1;
        wait_clk(6);
        check("R8 no spurious upd", {31'h0, upd_o}, 32'h0);
        do_latch("R8 empty latch");

        // R1/R2 full word, negative and positive codes
        send_word(32'h8001, 16);
        do_latch("R1 R2 8001");
        send_word(32'h7FFE, 16);
        do_latch("R2 7FFE");

        // R3 twenty bits: only the last sixteen remain
        send_word(32'hABCDE, 20);
        do_latch("R3 overrun");

        // R4 four bits: stale bits move up
        send_word(32'h5, 4);
        do_latch("R4 short");

        // R10 data toggles with bit clock held high, then latch
        for (int i = 0; i < 6; i++) begin
            sdata_i = ~sdata_i;
            wait_clk(3);
        end
        do_latch("R10 no shift");

        // R6 rising latch alone
        latch_i = 1'b0;
        wait_clk(6);
        begin
            int seen = 0;
            latch_i = 1'b1;
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                if (upd_o) seen++;
            end
            check("R6 no upd on rise", seen, 0);
            check("R6 code held", {16'h0, code_o}, {16'h0, model_code});
        end

        // Random lengths and words
        for (int k = 0; k < 24; k++) begin
            int n = 1 + ($urandom % 24);
            send_word($urandom, n);
            do_latch(n > 16 ? "R3 random" : (n < 16 ? "R4 random" : "R2 random"));
            check("R6 hold", {16'h0, code_o}, {16'h0, model_code});
        end

        done = 1'b1;
        finish_run();
    end

endmodule